// File: doc/BRIEF.md
# Quarter-Wave Quadrature Sine/Cosine Generator

This block is the amplitude stage behind a phase accumulator in a direct digital synthesizer. Each cycle that a phase word arrives with its valid strobe, the block produces one signed sine sample and one signed cosine sample for that phase. Two cycles later both samples leave together, with their own valid strobe.

The low phase bits are discarded, so only the upper ADDR_W+2 bits address the waveform. The two topmost of those bits pick the quadrant. The lookup table stores magnitudes for the first quadrant only. Quadrant decode mirrors the in-quadrant address (bit inversion) in the second and fourth quadrants and negates the magnitude in the lower half turn. The cosine path runs the same decode on the truncated phase advanced by a quarter turn, through a second read port of the same table, so both outputs always belong to the same input sample.

The table entry at address k holds round((2^(OUT_W-1)-1) * sin(pi/2 * (k+0.5) / 2^ADDR_W)). With the half-step offset, a mirrored address lands exactly on the symmetric angle. The table contents are computed when the design is elaborated.

Top module: `quad_sincos`

## Requirements
- R1: While rst_ni is low, sample_valid_o is 0 and sin_o and cos_o are 0. This holds even when phase_valid_i is high during reset.
- R2: With t = phase_i[19:10] (the top 10 bits, read as an unsigned number), sin_o equals round(511*sin(2*pi*(t+0.5)/1024)) to within 1 LSB. The lower 10 phase bits have no effect on the result.
- R3: cos_o equals the R2 value for index (t+256) mod 1024, so cos_o for index t is exactly sin_o for index (t+256) mod 1024.
- R4: sample_valid_o is high exactly two clock cycles after phase_valid_i was high and low otherwise. This holds for back-to-back and gapped input, with one output per input.
- R5: While sample_valid_o is low, sin_o and cos_o keep their previous values.
- R6: The outputs stay within -511..+511, and the code -512 never appears.
- R7: Bit 18 set mirrors the in-quadrant address, so sin for index 256+a equals sin for index 255-a exactly. Bit 19 set negates the result, so sin for index 512+a equals minus sin for index a exactly, for a in 0..255. The sign of sin_o follows bit 19 of the phase that produced it.
- R8: For every output sample, sin_o^2 + cos_o^2 lies between 509^2 and 513^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_valid_i | input | 1 | Phase word valid |
| phase_i | input | 20 | Phase word, a full turn is 2^20 |
| sample_valid_o | output | 1 | Output samples valid |
| sin_o | output | 10 | Signed sine sample |
| cos_o | output | 10 | Signed cosine sample |

## Verification
Some properties are checked on every cycle by the assertions:
- the two-cycle pairing of input and output strobes;
- the hold of the outputs between samples;
- the absence of the -512 code;
- the sign of the sine and cosine against the originating quadrant;
- the sum-of-squares bound that ties the two channels together.

Other properties rest on the bench's sweeps:
- the amplitude of every one of the 1024 phase indices against a real-valued reference;
- the insensitivity to the truncated low bits;
- the exact mirror and negation identities between quadrants;
- the exact quarter-turn relation between the cosine and sine tables.

// File: rtl/quad_sincos_pkg.sv
package quad_sincos_pkg;

  // pi * 2^30, fixed point
  localparam longint PI_FX = 64'sd3373259426;

  // Rounded quarter-wave magnitude for table entry k, computed at elaboration
  function automatic longint quarter_sine_mag(input int k, input int addr_w, input int mag_w);
    longint x;
    longint term;
    longint sum;
    longint amp;
    x    = (PI_FX * longint'(2 * k + 1)) >>> (addr_w + 2);
    term = x;
    sum  = x;
    for (int n = 1; n <= 7; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -(term / longint'((2 * n) * (2 * n + 1)));
      sum  = sum + term;
    end
    amp = (longint'(1) <<< mag_w) - 1;
    return (sum * amp + (longint'(1) <<< 29)) >>> 30;
  endfunction

endpackage

// File: rtl/quad_fold.sv
module quad_fold #(
  parameter int ADDR_W  = 8,
  parameter int QUARTER = 0
) (
  input  logic [ADDR_W+1:0] trunc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              neg_o
);
  localparam int TW = ADDR_W + 2;

  logic [TW-1:0] shifted;

  always_comb begin
    shifted = trunc_i + (TW'(QUARTER) << ADDR_W);
    // second MSB mirrors within the quadrant, MSB flips the sign
    addr_o  = shifted[TW-2] ? ~shifted[ADDR_W-1:0] : shifted[ADDR_W-1:0];
    neg_o   = shifted[TW-1];
  end
endmodule

// File: rtl/quarter_rom.sv
module quarter_rom
  import quad_sincos_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MAG_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  output logic [MAG_W-1:0]  mag_a_o,
  output logic [MAG_W-1:0]  mag_b_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam logic [MAG_W-1:0] ENTRY = MAG_W'(quarter_sine_mag(k, ADDR_W, MAG_W));
    assign tbl[k] = ENTRY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_a_o <= '0;
      mag_b_o <= '0;
    end else if (en_i) begin
      mag_a_o <= tbl[addr_a_i];
      mag_b_o <= tbl[addr_b_i];
    end
  end
endmodule

// File: rtl/sign_apply.sv
module sign_apply #(
  parameter int OUT_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [OUT_W-2:0]        mag_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam logic signed [OUT_W:0] LO_LIM = -((OUT_W+1)'(1) <<< (OUT_W - 1)) + (OUT_W+1)'(1);

  logic signed [OUT_W:0] wide;
  logic signed [OUT_W:0] sat;

  always_comb begin
    wide = $signed({2'b00, mag_i});
    if (neg_i) wide = -wide;
    // keep the most negative code out of range
    sat = (wide < LO_LIM) ? LO_LIM : wide;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sample_o <= '0;
    else if (en_i) sample_o <= sat[OUT_W-1:0];
  end
endmodule

// File: rtl/quad_sincos.sv
module quad_sincos #(
  parameter int PHASE_W = 20,
  parameter int ADDR_W  = 8,
  parameter int OUT_W   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_valid_i,
  input  logic [PHASE_W-1:0]      phase_i,
  output logic                    sample_valid_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int TW    = ADDR_W + 2;
  localparam int MAG_W = OUT_W - 1;
  localparam int NCH   = 2;

  logic [ADDR_W-1:0]       addr  [NCH];
  logic [MAG_W-1:0]        mag   [NCH];
  logic signed [OUT_W-1:0] smp   [NCH];
  logic [NCH-1:0]          neg;
  logic [NCH-1:0]          neg_q;
  logic                    lut_vld_q;
  logic                    out_vld_q;
  logic                    unused_low_phase;

  assign unused_low_phase = ^phase_i[PHASE_W-TW-1:0];

  // channel 0: sine, channel 1: cosine (quarter turn ahead)
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    quad_fold #(.ADDR_W(ADDR_W), .QUARTER(ch)) u_fold (
      .trunc_i(phase_i[PHASE_W-1 -: TW]),
      .addr_o (addr[ch]),
      .neg_o  (neg[ch])
    );
    sign_apply #(.OUT_W(OUT_W)) u_sign (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (lut_vld_q),
      .mag_i   (mag[ch]),
      .neg_i   (neg_q[ch]),
      .sample_o(smp[ch])
    );
  end

  quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (phase_valid_i),
    .addr_a_i(addr[0]),
    .addr_b_i(addr[1]),
    .mag_a_o (mag[0]),
    .mag_b_o (mag[1])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q     <= '0;
      lut_vld_q <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      if (phase_valid_i) neg_q <= neg;
      lut_vld_q <= phase_valid_i;
      out_vld_q <= lut_vld_q;
    end
  end

  assign sample_valid_o = out_vld_q;
  assign sin_o          = smp[0];
  assign cos_o          = smp[1];
endmodule

// File: rtl/quad_sincos_chk.sv
module quad_sincos_chk #(
  parameter int PHASE_W = 20,
  parameter int OUT_W   = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    phase_valid_i,
  input logic [PHASE_W-1:0]      phase_i,
  input logic                    sample_valid_o,
  input logic signed [OUT_W-1:0] sin_o,
  input logic signed [OUT_W-1:0] cos_o
);
  localparam int AMP   = (1 << (OUT_W - 1)) - 1;
  localparam int R2_LO = (AMP - 2) * (AMP - 2);
  localparam int R2_HI = (AMP + 2) * (AMP + 2);
  localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  a_r4_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_valid_i |-> ##2 sample_valid_o);

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_valid_i |-> ##2 !sample_valid_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_o |-> ($stable(sin_o) && $stable(cos_o)));

  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (sin_o != MIN_CODE && cos_o != MIN_CODE));

  a_r7_sin_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> ($past(phase_i[PHASE_W-1], 2) ? (sin_o <= 0) : (sin_o >= 0)));

  a_r3_cos_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |->
      (($past(phase_i[PHASE_W-1], 2) ^ $past(phase_i[PHASE_W-2], 2)) ? (cos_o <= 0) : (cos_o >= 0)));

  a_r8_quadrature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |->
      ((int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o)) >= R2_LO &&
       (int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o)) <= R2_HI));

  always_comb begin
    if (!rst_ni) a_r1_reset: assert (!sample_valid_o);
  end
endmodule

bind quad_sincos quad_sincos_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .phase_valid_i (phase_valid_i),
  .phase_i       (phase_i),
  .sample_valid_o(sample_valid_o),
  .sin_o         (sin_o),
  .cos_o         (cos_o)
);

// File: tb/quad_sincos_test.sv
module quad_sincos_test;
  localparam int  PHASE_W    = 20;
  localparam int  ADDR_W     = 8;
  localparam int  OUT_W      = 10;
  localparam int  TW         = ADDR_W + 2;
  localparam int  NIDX       = 1 << TW;
  localparam int  QTR        = 1 << ADDR_W;
  localparam int  AMP        = (1 << (OUT_W - 1)) - 1;
  localparam time CLK_PERIOD = 10ns;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    pv;
  logic [PHASE_W-1:0]      phase;
  logic                    sv;
  logic signed [OUT_W-1:0] sin_s;
  logic signed [OUT_W-1:0] cos_s;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_ph[$];
  int exp_cy[$];
  int sin_tab[NIDX];
  int cos_tab[NIDX];
  int last_sin = 0;
  int last_cos = 0;

  quad_sincos #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .phase_valid_i (pv),
    .phase_i       (phase),
    .sample_valid_o(sv),
    .sin_o         (sin_s),
    .cos_o         (cos_s)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ref_amp(int t, bit is_cos);
    real th, v;
    th = 2.0 * 3.14159265358979 * (real'(t) + 0.5 + (is_cos ? real'(QTR) : 0.0)) / real'(NIDX);
    v  = real'(AMP) * $sin(th);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(bit v, logic [PHASE_W-1:0] p);
    int ph, st, t, es, ec, s, c, r2;
    @(negedge clk);
    cyc++;
    s = int'(sin_s);
    c = int'(cos_s);
    if (sv) begin
      if (exp_ph.size() == 0) begin
        check(1'b0, "R4 sample without input", 1, 0);
      end else begin
        ph = exp_ph.pop_front();
        st = exp_cy.pop_front();
        t  = ph >> (PHASE_W - TW);
        check(st == cyc - 2, "R4 latency", cyc - st, 2);
        es = ref_amp(t, 1'b0);
        ec = ref_amp(t, 1'b1);
        check((s - es) <= 1 && (es - s) <= 1, "R2 sine value", s, es);
        check((c - ec) <= 1 && (ec - c) <= 1, "R3 cosine value", c, ec);
        check(s >= -AMP && c >= -AMP && s <= AMP && c <= AMP, "R6 range", (s < c) ? s : c, -AMP);
        r2 = s * s + c * c;
        check(r2 >= (AMP - 2) * (AMP - 2) && r2 <= (AMP + 2) * (AMP + 2), "R8 quadrature", r2, AMP * AMP);
        sin_tab[t] = s;
        cos_tab[t] = c;
      end
    end else begin
      check(s == last_sin && c == last_cos, "R5 hold", s, last_sin);
      if (exp_cy.size() != 0) check(exp_cy[0] != cyc - 2, "R4 missing sample", 0, 1);
    end
    last_sin = s;
    last_cos = c;
    pv    = v;
    phase = p;
    if (v) begin
      exp_ph.push_back(int'(p));
      exp_cy.push_back(cyc);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pv    = 1'b1;
    phase = 20'h4_0000;
    repeat (3) @(negedge clk);
    // R1: reset state, input strobe ignored in reset
    check(sv == 1'b0, "R1 valid in reset", int'(sv), 0);
    check(sin_s == 0, "R1 sine in reset", int'(sin_s), 0);
    check(cos_s == 0, "R1 cosine in reset", int'(cos_s), 0);
    pv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // back-to-back sweep of every index, varied low bits (R2 truncation)
    for (int t = 0; t < NIDX; t++) begin
      step(1'b1, (PHASE_W'(t) << (PHASE_W - TW)) | PHASE_W'((t * 613 + 77) % NIDX));
    end
    repeat (4) step(1'b0, '0);

    // R7 mirror and negation, R3 quarter-turn identity
    for (int a = 0; a < QTR; a++) begin
      check(sin_tab[QTR + a] == sin_tab[QTR - 1 - a], "R7 mirror", sin_tab[QTR + a], sin_tab[QTR - 1 - a]);
      check(sin_tab[2 * QTR + a] == -sin_tab[a], "R7 negate", sin_tab[2 * QTR + a], -sin_tab[a]);
    end
    for (int t = 0; t < NIDX; t++) begin
      check(cos_tab[t] == sin_tab[(t + QTR) % NIDX], "R3 quarter turn", cos_tab[t], sin_tab[(t + QTR) % NIDX]);
    end

    // gapped input, other low bits (R4, R5, R2)
    for (int i = 0; i < 900; i++) begin
      step((i % 3) != 1, (PHASE_W'((i * 37 + 5) % NIDX) << (PHASE_W - TW)) | PHASE_W'((i * 101) % NIDX));
    end
    repeat (4) step(1'b0, '0);
    check(exp_ph.size() == 0, "R4 one output per input", exp_ph.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule